// File: doc/BRIEF.md
# Snapshot-and-Clear Saturating Error Counter

This block keeps a running tally of single-cycle error strobes coming from a line receiver. The tally is 16 bits wide and sticks at its top value instead of wrapping. A host capture bit, sampled in the same clock domain, takes a snapshot. On each 0-to-1 step of that bit the live tally is moved into a holding register and the live tally restarts from zero, both in the same clock edge.

Software reads the snapshot as two bytes through a small synchronous address and read-data port. The high byte and the low byte come from the same holding register, so a pair of reads between two captures always belongs to one snapshot. A separate output gives one pulse for each error when the non-return-to-zero output mode is selected.

Top module: `err_snap_counter`

## Requirements
- R1: After reset the live tally and the holding register are zero, so reads at 0x11 and 0x12 both return 0x00.
- R2: When snap_req is sampled high at a clock edge after being low at the previous edge, the holding register takes the tally counted before that edge and the tally is cleared. The new snapshot is visible on rd_data right after that edge.
- R3: Keeping snap_req high causes no further capture. The holding register keeps its value, the tally keeps counting, and snap_req must return low before another 0-to-1 step can capture again.
- R4: Each clock edge with err_strobe high adds one to the tally.
- R5: The tally saturates at 65535. Later errors leave it at 65535, with no wrap to zero.
- R6: An error strobe at the same edge as a capture is counted into the cleared tally, so the tally restarts at 1.
- R7: rd_data is combinational from rd_addr. Address 0x11 returns snapshot bits 15..8, address 0x12 returns bits 7..0, and any other address returns 0x00.
- R8: With nrz_mode high, err_pulse_o is high for exactly the one cycle after each edge at which err_strobe is high. With nrz_mode low, err_pulse_o stays low.
- R9: The holding register changes only at a capture, so both bytes always show the same snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_strobe | input | 1 | One-cycle error indication |
| snap_req | input | 1 | Host capture bit; a 0-to-1 step captures and clears |
| nrz_mode | input | 1 | Enables the per-error output pulse |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Byte read from the snapshot |
| err_pulse_o | output | 1 | Registered per-error pulse |

## Verification
The bench attacks four corner cases.

- A capture bit held high. A design that looks at the level instead of the edge would keep clearing the tally and overwrite the snapshot.
- An error landing on the capture edge. A design that drops it would restart at 0 instead of 1.
- A long run of errors past 65535. A design that wraps would read back a small value instead of 0xFFFF.
- Tallies that cross a byte boundary, such as 255 and 256, and reads at addresses next to the two mapped ones. These show swapped, misaligned or aliased byte lanes.

// File: rtl/esc_pkg.sv
`timescale 1ns/1ps
package esc_pkg;
  // Next tally value: add one on a hit unless already at the ceiling.
  function automatic logic [31:0] sat_step(logic [31:0] cur, logic [31:0] ceil, logic hit);
    if (hit && (cur != ceil)) return cur + 32'd1;
    return cur;
  endfunction

  // Byte number idx (0 = least significant) of a word.
  function automatic logic [7:0] byte_of(logic [31:0] word, int idx);
    logic [31:0] shifted;
    shifted = word >> (idx * 8);
    return shifted[7:0];
  endfunction
endpackage

// File: rtl/esc_edge.sv
`timescale 1ns/1ps
module esc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R3
  no_back_to_back_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/esc_counter.sv
`timescale 1ns/1ps
module esc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  import esc_pkg::*;
  localparam logic [CNT_W-1:0] CEIL = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i) cnt_d = hit_i ? CNT_W'(1) : '0;
    else       cnt_d = CNT_W'(sat_step(32'(cnt_q), 32'(CEIL), hit_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == CEIL) |=> (cnt_q == CEIL));
  // R4
  no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q >= $past(cnt_q)));
  // R6
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == CNT_W'($past(hit_i))));
endmodule

// File: rtl/esc_hold.sv
`timescale 1ns/1ps
module esc_hold #(
  parameter int          CNT_W  = 16,
  parameter int          ADDR_W = 8,
  parameter int unsigned BASE   = 32'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [CNT_W-1:0]  hold_o
);
  import esc_pkg::*;
  localparam int NBYTES = (CNT_W + 7) / 8;

  logic [CNT_W-1:0] hold_q;
  logic [NBYTES-1:0] byte_hit;
  logic [7:0] byte_val [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (cap_i) hold_q <= cnt_i;
  end

  // Most significant byte at BASE, lower bytes at following addresses.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign byte_hit[g] = (rd_addr_i == ADDR_W'(BASE + g));
    assign byte_val[g] = byte_of(32'(hold_q), NBYTES - 1 - g);
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NBYTES; i++)
      if (byte_hit[i]) rd_data_o = rd_data_o | byte_val[i];
  end

  assign hold_o = hold_q;

  // R7
  lane_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_hit));
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(hold_q));
  // R2
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (hold_q == $past(cnt_i)));
endmodule

// File: rtl/err_snap_counter.sv
`timescale 1ns/1ps
module err_snap_counter #(
  parameter int          CNT_W  = 16,
  parameter int          ADDR_W = 8,
  parameter int unsigned BASE   = 32'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_strobe,
  input  logic              snap_req,
  input  logic              nrz_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              err_pulse_o
);
  logic             capture_evt;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] held_cnt;
  logic             pulse_q;

  esc_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (snap_req),
    .rise_o (capture_evt)
  );

  esc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_i (err_strobe),
    .clr_i (capture_evt),
    .cnt_o (live_cnt)
  );

  esc_hold #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (capture_evt),
    .cnt_i     (live_cnt),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .hold_o    (held_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= err_strobe & nrz_mode;
  end

  assign err_pulse_o = pulse_q;

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse_o && !$past(err_pulse_o)) |-> ($past(err_strobe) && $past(nrz_mode)));
  // R3
  capture_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (!capture_evt && held_cnt == $past(live_cnt)));
endmodule

// File: tb/sim_err_snap_counter.sv
`timescale 1ns/1ps
module sim_err_snap_counter;
  logic clk = 0, rst_n = 0, err_strobe = 0, snap_req = 0, nrz_mode = 0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic err_pulse_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  err_snap_counter u0 (.clk(clk), .rst_n(rst_n), .err_strobe(err_strobe),
    .snap_req(snap_req), .nrz_mode(nrz_mode), .rd_addr(rd_addr),
    .rd_data(rd_data), .err_pulse_o(err_pulse_o));

  // {error cycles, expected snapshot}
  localparam logic [31:0] VEC [6] = '{
    {16'd0, 16'h0000}, {16'd1, 16'h0001}, {16'd7, 16'h0007},
    {16'd255, 16'h00FF}, {16'd256, 16'h0100}, {16'd771, 16'h0303}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic errs(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); err_strobe = 1; end
    @(negedge clk); err_strobe = 0;
  endtask

  task automatic capture();
    @(negedge clk); snap_req = 1;
    @(negedge clk); snap_req = 0;
  endtask

  task automatic read16(output logic [15:0] v);
    rd_addr = 8'h11; #1; v[15:8] = rd_data;
    rd_addr = 8'h12; #1; v[7:0] = rd_data;
  endtask

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    read16(v); chk("R1", v, 16'h0000);
    rst_n = 1;
    capture(); read16(v); chk("R1", v, 16'h0000);

    // R2 R4 R7: table walk
    for (int k = 0; k < 6; k++) begin
      errs(int'(VEC[k][31:16]));
      capture(); read16(v);
      chk("R2_R4", v, VEC[k][15:0]);
    end
    // R7: byte lanes and unmapped addresses, snapshot is 0x0303
    rd_addr = 8'h10; #1; chk("R7", rd_data, 8'h00);
    rd_addr = 8'h13; #1; chk("R7", rd_data, 8'h00);
    errs(2); capture();
    rd_addr = 8'h11; #1; chk("R7", rd_data, 8'h00);
    rd_addr = 8'h12; #1; chk("R7", rd_data, 8'h02);

    // R3 R9: held-high capture bit does not re-capture
    errs(5);
    @(negedge clk); snap_req = 1;
    @(negedge clk);
    read16(v); chk("R3", v, 16'h0005);
    errs(3);
    read16(v); chk("R9", v, 16'h0005);
    @(negedge clk); snap_req = 0;
    capture(); read16(v); chk("R3", v, 16'h0003);

    // R6: error on the capture edge restarts at 1
    errs(4);
    @(negedge clk); snap_req = 1; err_strobe = 1;
    @(negedge clk); snap_req = 0; err_strobe = 0;
    read16(v); chk("R6", v, 16'h0004);
    capture(); read16(v); chk("R6", v, 16'h0001);

    // R8: per-error pulse
    nrz_mode = 1;
    @(negedge clk); err_strobe = 1;
    @(negedge clk); err_strobe = 0; chk("R8", err_pulse_o, 1);
    @(negedge clk); chk("R8", err_pulse_o, 0);
    nrz_mode = 0;
    @(negedge clk); err_strobe = 1;
    @(negedge clk); err_strobe = 0; chk("R8", err_pulse_o, 0);
    capture();

    // R5: saturation
    errs(65540);
    capture(); read16(v); chk("R5", v, 16'hFFFF);
    capture(); read16(v); chk("R5", v, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule